// File: doc/BRIEF.md
# Grouped Interrupt Vector Controller

This block gathers a wide set of edge-type interrupt vectors into groups of 32 and raises one interrupt line per group toward a parent controller. Each group keeps two 32-bit words: a pending word that latches vector edges, and an enable word that masks them. Vector n belongs to group n/32, at bit n mod 32. The number of groups is a build parameter from 1 to 8.

Software uses a small 32-bit register bus. A service routine reads a pending word to find the vectors that fired. It then writes ones to that word to acknowledge them. The enable words are plain read/write storage, so software changes a single mask bit with a read-modify-write. Requests are single-cycle strobes. The block accepts one request in every cycle and applies no back-pressure. A read answers exactly one cycle after its request, and a write gives no response.

Top module: `grpvec_intc`

## Requirements
- R1: After reset every enable bit and every pending bit is 0, every irq_out bit is low and rsp_valid is low.
- R2: Vector n maps to group n/32, bit n mod 32. The pending word of group i is at byte address 4*i. The enable word of group i is at byte address 0x20 + 4*i.
- R3: A 0-to-1 transition on a vector whose enable bit is 1 sets its pending bit. The bit stays set until acknowledged. An input that is simply held high does not set the bit again after it has been acknowledged.
- R4: A rising edge on a vector whose enable bit is 0 is dropped. The pending bit stays 0, even if the enable bit is set later.
- R5: A write to a pending word clears each bit written as 1 and leaves each bit written as 0 unchanged.
- R6: A write to an enable word replaces all 32 enable bits of that group, and a read returns the value last written.
- R7: irq_out[i] is high exactly when the bitwise AND of group i's pending and enable words is nonzero. Clearing an enable bit lowers the line but leaves the pending bit set.
- R8: When an acknowledge and a new rising edge reach the same bit in the same cycle, the bit remains pending.
- R9: A read request gives rsp_valid high for exactly one cycle, the cycle after the request, with the data in rsp_rdata. A write request raises no response.
- R10: Reads of a group index at or above the group count, of any address outside the two word banks, or of a non-word-aligned address return 0. Writes to such addresses change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_in | input | 32*NGROUPS | Interrupt vector inputs, edge-sensitive |
| req_valid | input | 1 | Bus request strobe, one request per cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | NGROUPS | Per-group interrupt line to the parent controller |

## Verification
The assertions assume that vec_in and the bus inputs are never unknown once reset is released. They also assume that a request is held for a single cycle, so each cycle with req_valid high counts as a new request. The bench meets both assumptions: every input is driven from a known value at time zero and changes only on falling clock edges. Every bus access strobes req_valid for exactly one cycle. Vector pulses and acknowledges are timed so that, apart from the deliberate same-cycle race, an edge and a write never meet on the same bit.

// File: rtl/gvic_pkg.sv
package gvic_pkg;
  localparam int unsigned VEC_PER_GRP = 32;
  localparam int unsigned MAX_GRP     = 8;
  localparam int unsigned BANK_SHIFT  = 5;   // 0x20 separates the two banks
  localparam int unsigned BANK_PEND   = 0;
  localparam int unsigned BANK_EN     = 1;
endpackage

// File: rtl/gvic_edge.sv
module gvic_edge #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lvl,
  output logic [W-1:0] rise
);
  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= lvl;
  end

  assign rise = lvl & ~prev_q;
endmodule

// File: rtl/gvic_group.sv
module gvic_group #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] rise,
  input  logic         wr_pend,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] pend,
  output logic [W-1:0] en,
  output logic [W-1:0] clr,
  output logic         irq
);
  logic [W-1:0] pend_q, en_q;

  assign clr = wr_pend ? wdata : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q <= '0;
      en_q   <= '0;
    end else begin
      if (wr_en) en_q <= wdata;
      // set term is applied after the clear, so a same-cycle edge survives
      pend_q <= (pend_q & ~clr) | (rise & en_q);
    end
  end

  assign pend = pend_q;
  assign en   = en_q;
  assign irq  = |(pend_q & en_q);
endmodule

// File: rtl/gvic_regbus.sv
module gvic_regbus
  import gvic_pkg::*;
#(
  parameter int unsigned NG     = 8,
  parameter int unsigned ADDR_W = 8,
  localparam int unsigned NV    = NG * VEC_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [NV-1:0]     pend_all,
  input  logic [NV-1:0]     en_all,
  output logic [NG-1:0]     wr_pend,
  output logic [NG-1:0]     wr_en,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata
);
  localparam int unsigned BW = ADDR_W - BANK_SHIFT;

  logic [2:0]    idx;
  logic [BW-1:0] bank;
  logic          aligned;
  logic          hit_pend, hit_en;
  logic [31:0]   rd_next;

  assign idx      = req_addr[4:2];
  assign bank     = req_addr[ADDR_W-1:BANK_SHIFT];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign hit_pend = aligned && (bank == BW'(BANK_PEND));
  assign hit_en   = aligned && (bank == BW'(BANK_EN));

  for (genvar g = 0; g < NG; g++) begin : g_strobe
    assign wr_pend[g] = req_valid && req_write && hit_pend && (idx == 3'(g));
    assign wr_en[g]   = req_valid && req_write && hit_en   && (idx == 3'(g));
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < NG; g++) begin
      if (idx == 3'(g)) begin
        if (hit_pend) rd_next = pend_all[g*VEC_PER_GRP +: VEC_PER_GRP];
        if (hit_en)   rd_next = en_all[g*VEC_PER_GRP +: VEC_PER_GRP];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      rsp_rdata <= (req_valid && !req_write) ? rd_next : '0;
    end
  end
endmodule

// File: rtl/grpvec_intc.sv
module grpvec_intc
  import gvic_pkg::*;
#(
  parameter int unsigned NGROUPS = 8,
  parameter int unsigned ADDR_W  = 8,
  localparam int unsigned NV     = NGROUPS * VEC_PER_GRP
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NV-1:0]     vec_in,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic [NGROUPS-1:0] irq_out
);
  logic [NV-1:0]      rise_all, pend_all, en_all, clr_all;
  logic [NGROUPS-1:0] wr_pend, wr_en;

  gvic_edge #(.W(NV)) u_edge (
    .clk(clk), .rst_n(rst_n), .lvl(vec_in), .rise(rise_all)
  );

  gvic_regbus #(.NG(NGROUPS), .ADDR_W(ADDR_W)) u_bus (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .pend_all(pend_all), .en_all(en_all),
    .wr_pend(wr_pend), .wr_en(wr_en),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
  );

  for (genvar g = 0; g < NGROUPS; g++) begin : g_grp
    gvic_group #(.W(VEC_PER_GRP)) u_grp (
      .clk(clk), .rst_n(rst_n),
      .rise(rise_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .wr_pend(wr_pend[g]), .wr_en(wr_en[g]), .wdata(req_wdata),
      .pend(pend_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .en(en_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .clr(clr_all[g*VEC_PER_GRP +: VEC_PER_GRP]),
      .irq(irq_out[g])
    );
  end
endmodule

// File: rtl/grpvec_intc_chk.sv
module grpvec_intc_chk #(
  parameter int unsigned NG = 8,
  parameter int unsigned NV = 256
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic          rsp_valid,
  input logic [NV-1:0] pend_all,
  input logic [NV-1:0] en_all,
  input logic [NV-1:0] clr_all,
  input logic [NG-1:0] irq_out
);
  logic primed;
  always_ff @(posedge clk) begin
    if (!rst_n) primed <= 1'b0;
    else        primed <= 1'b1;
  end

  AST_PEND_STICKY: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ((pend_all & $past(pend_all & ~clr_all)) == $past(pend_all & ~clr_all))); // R3
  AST_MASKED_NO_SET: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    ((pend_all & ~$past(pend_all) & ~$past(en_all)) == '0)); // R4
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n || !primed)
    (rsp_valid == $past(req_valid && !req_write))); // R9
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_all == '0) |-> (irq_out == '0)); // R7
endmodule

bind grpvec_intc grpvec_intc_chk #(.NG(NGROUPS), .NV(NV)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
  .rsp_valid(rsp_valid), .pend_all(pend_all), .en_all(en_all),
  .clr_all(clr_all), .irq_out(irq_out)
);

// File: tb/grpvec_intc_test.sv
module grpvec_intc_test;
  localparam int NG = 3;
  localparam int NV = NG * 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NV-1:0] vec_in = '0;
  logic          req_valid = 1'b0, req_write = 1'b0;
  logic [7:0]    req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic          rsp_valid;
  logic [31:0]   rsp_rdata;
  logic [NG-1:0] irq_out;

  int checks = 0, errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  grpvec_intc #(.NGROUPS(NG), .ADDR_W(8)) uut (
    .clk(clk), .rst_n(rst_n), .vec_in(vec_in),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 0; req_write = 0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a;
    @(negedge clk);
    req_valid = 0;
    chk("R9 rsp_valid on read", {31'b0, rsp_valid}, 32'd1);
    d = rsp_rdata;
    @(negedge clk);
    chk("R9 rsp_valid one cycle", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic pulse(int n);
    @(negedge clk); vec_in[n] = 1;
    @(negedge clk); vec_in[n] = 0;
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 irq_out after reset", {29'b0, irq_out}, 32'd0);
    chk("R1 rsp_valid after reset", {31'b0, rsp_valid}, 32'd0);
    bus_rd(8'h20, d); chk("R1 enable g0 zero", d, 32'd0);
    bus_rd(8'h04, d); chk("R1 pending g1 zero", d, 32'd0);
  endtask

  task automatic t_masked();
    logic [31:0] d;
    pulse(5);
    bus_wr(8'h20, 32'h0000_0020);
    bus_rd(8'h00, d); chk("R4 masked edge dropped", d, 32'd0);
    chk("R4 irq stays low", {29'b0, irq_out}, 32'd0);
  endtask

  task automatic t_capture_map();
    logic [31:0] d;
    bus_wr(8'h24, 32'h8000_0001);          // group 1 bits 0 and 31
    bus_rd(8'h24, d); chk("R6 enable readback", d, 32'h8000_0001);
    pulse(32 + 31);                          // vector 63 -> group 1 bit 31
    bus_rd(8'h04, d); chk("R2 vector 63 at group1 bit31", d, 32'h8000_0000);
    chk("R7 irq group1 high", {29'b0, irq_out}, 32'b010);
    bus_rd(8'h00, d); chk("R2 group0 untouched", d, 32'd0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    pulse(32);                               // group 1 bit 0
    bus_rd(8'h04, d); chk("R3 two bits pending", d, 32'h8000_0001);
    bus_wr(8'h04, 32'h0000_0001);
    bus_rd(8'h04, d); chk("R5 write-one clears only bit0", d, 32'h8000_0000);
    bus_wr(8'h04, 32'h0000_0000);
    bus_rd(8'h04, d); chk("R5 write zero no effect", d, 32'h8000_0000);
    bus_wr(8'h24, 32'h0000_0001);            // mask bit31
    @(negedge clk);
    chk("R7 irq low after mask", {29'b0, irq_out}, 32'd0);
    bus_rd(8'h04, d); chk("R7 pending kept when masked", d, 32'h8000_0000);
    bus_wr(8'h04, 32'hFFFF_FFFF);
    bus_rd(8'h04, d); chk("R5 clear all", d, 32'd0);
  endtask

  task automatic t_level_held();
    logic [31:0] d;
    @(negedge clk); vec_in[32] = 1;
    @(negedge clk);
    bus_wr(8'h04, 32'h0000_0001);
    repeat (3) @(negedge clk);
    bus_rd(8'h04, d); chk("R3 held level no re-set", d, 32'd0);
    vec_in[32] = 0;
  endtask

  task automatic t_race();
    logic [31:0] d;
    bus_wr(8'h28, 32'h0000_0100);            // group 2 bit 8
    pulse(64 + 8);
    repeat (2) @(negedge clk);
    req_valid = 1; req_write = 1; req_addr = 8'h08; req_wdata = 32'h0000_0100;
    vec_in[72] = 1;
    @(negedge clk);
    req_valid = 0; req_write = 0; vec_in[72] = 0;
    bus_rd(8'h08, d); chk("R8 edge wins over ack", d, 32'h0000_0100);
    chk("R7 irq group2 high", {29'b0, irq_out}, 32'b100);
  endtask

  task automatic t_unmapped();
    logic [31:0] d;
    bus_wr(8'h2C, 32'hFFFF_FFFF);            // group 3 enable: unused
    bus_rd(8'h2C, d); chk("R10 unused group reads zero", d, 32'd0);
    bus_wr(8'h41, 32'hFFFF_FFFF);
    bus_wr(8'h22, 32'hFFFF_FFFF);            // misaligned
    bus_rd(8'h20, d); chk("R10 misaligned write ignored", d, 32'h0000_0020);
    bus_rd(8'h09, d); chk("R10 misaligned read zero", d, 32'd0);
    bus_rd(8'h40, d); chk("R10 unmapped read zero", d, 32'd0);
    bus_rd(8'h08, d); chk("R10 pending intact", d, 32'h0000_0100);
    bus_wr(8'h08, 32'hFFFF_FFFF);
    @(negedge clk);
    chk("R9 no response to write", {31'b0, rsp_valid}, 32'd0);
    chk("R7 all irq low", {29'b0, irq_out}, 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_masked();
    t_capture_map();
    t_ack();
    t_level_held();
    t_race();
    t_unmapped();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule